// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the architectural registers of a 32-bit processor core that runs in one of seven operating modes. The core always names a register by a 4-bit logical index (0 to 15). The block turns that index into one of 31 physical storage words, based on the mode currently applied on its mode input. Privileged exception modes therefore see a private stack pointer (index 13) and link register (index 14). The fast-interrupt mode also has private copies of indices 8 to 12, so its handler can run without saving them first.

Index 15 is the program counter. It is one word shared by every mode. There are two combinational read ports and one write port, and all three use the same mode input. A write lands on the clock edge. A read of the same word in that cycle still returns the old contents.

Top module: `banked_regfile`

## Requirements
- R1: After reset is released, every logical index reads as zero in every mode.
- R2: Indices 0 to 7 select the same physical words in all modes.
- R3: Indices 8 to 12 are one shared set in all modes except fast interrupt (mode code 10001), which has a private set of its own.
- R4: Indices 13 and 14 have separate private copies in fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011). These are distinct from each other and from the user copy.
- R5: User mode (10000) and system mode (11111) address the same physical words at every index.
- R6: Index 15 is one word shared by all modes. Any write to it stores the data with bits 1:0 forced to zero.
- R7: A read of the word being written in the same cycle returns the previous value. The new value appears from the following cycle on.
- R8: Any mode code other than the seven listed selects the user-mode mapping.
- R9: When the write enable is low, no stored word changes.
- R10: The two read ports decode their indices independently and may address any pair of indices, including the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all storage |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index for the write port |
| wr_data | input | DATA_W | Write data |

## Verification
The first pattern fills every index with a distinct value in one mode, then reads all of them back in each of the other modes. This shows which words are shared and which are banked, and it catches a bank that aliases the user copy or another exception bank. The second pattern writes indices 13 and 14 in each exception mode in turn, which would expose any crossed bank offset. Further cases cover a write and read of the same word in one cycle, writes with the enable low, program counter writes with low bits set, and the unlisted mode codes. A long random run then mixes modes, indices and enables against a model that keys storage by bank name.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
   localparam int MODE_W   = 5;
   localparam int IDX_W    = 4;
   localparam int NUM_PHYS = 31;
   localparam int PHYS_W   = $clog2(NUM_PHYS);
   localparam int PC_IDX   = 15;

   localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5
   } bank_e;

   // physical layout: 0..14 user, 15 pc, 16..22 fiq r8..r14,
   // 23/24 irq, 25/26 svc, 27/28 abt, 29/30 und (r13/r14)
   localparam logic [PHYS_W-1:0] OFS_FIQ = 5'd8;
   localparam logic [PHYS_W-1:0] OFS_IRQ = 5'd10;
   localparam logic [PHYS_W-1:0] OFS_SVC = 5'd12;
   localparam logic [PHYS_W-1:0] OFS_ABT = 5'd14;
   localparam logic [PHYS_W-1:0] OFS_UND = 5'd16;
endpackage

// File: rtl/bankrf_mode_decode.sv
module bankrf_mode_decode
   import bankrf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output bank_e             bank_o
);
   always_comb begin
      case (mode_i)
         MD_FIQ:  bank_o = BK_FIQ;
         MD_IRQ:  bank_o = BK_IRQ;
         MD_SVC:  bank_o = BK_SVC;
         MD_ABT:  bank_o = BK_ABT;
         MD_UND:  bank_o = BK_UND;
         default: bank_o = BK_USR;
      endcase
   end

   // system mode shares the user bank
   assert_sys_is_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SYS) |-> (bank_o == BK_USR));

   // codes outside the seven listed fall back to user
   assert_invalid_is_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MD_USR && mode_i != MD_FIQ && mode_i != MD_IRQ && mode_i != MD_SVC &&
       mode_i != MD_ABT && mode_i != MD_UND && mode_i != MD_SYS) |-> (bank_o == BK_USR));
endmodule

// File: rtl/bankrf_index_map.sv
module bankrf_index_map
   import bankrf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  bank_e             bank_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [PHYS_W-1:0] phys_o
);
   logic [PHYS_W-1:0] ofs;
   logic              hi_fiq;
   logic              is_spl;

   assign hi_fiq = (idx_i >= 4'd8) && (idx_i <= 4'd14);
   assign is_spl = (idx_i == 4'd13) || (idx_i == 4'd14);

   always_comb begin
      ofs = '0;
      unique case (bank_i)
         BK_FIQ:  if (hi_fiq) ofs = OFS_FIQ;
         BK_IRQ:  if (is_spl) ofs = OFS_IRQ;
         BK_SVC:  if (is_spl) ofs = OFS_SVC;
         BK_ABT:  if (is_spl) ofs = OFS_ABT;
         BK_UND:  if (is_spl) ofs = OFS_UND;
         default: ofs = '0;
      endcase
   end

   assign phys_o = PHYS_W'(idx_i) + ofs;

   assert_phys_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phys_o < PHYS_W'(NUM_PHYS));

   assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_i < 4'd8) |-> (phys_o == PHYS_W'(idx_i)));

   assert_pc_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_i == 4'(PC_IDX)) |-> (phys_o == PHYS_W'(PC_IDX)));

   assert_exc_private_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_spl && bank_i != BK_USR) |-> (phys_o >= 5'd16));

   assert_mid_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_i >= 4'd8 && idx_i <= 4'd12 && bank_i != BK_FIQ) |-> (phys_o == PHYS_W'(idx_i)));
endmodule

// File: rtl/bankrf_store.sv
module bankrf_store
   import bankrf_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int NUM_RD         = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PHYS_W-1:0] wr_phys,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PHYS_W-1:0] rd_phys [NUM_RD],
   output logic [DATA_W-1:0] rd_data [NUM_RD]
);
   logic [DATA_W-1:0] mem [NUM_PHYS];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) mem[i] <= '0;
         end else if (wr_en) begin
            mem[wr_phys] <= wr_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_phys] <= wr_data;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_data[p] = mem[rd_phys[p]];
   end

   assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_phys)] == $past(wr_data)));

   assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_phys == PHYS_W'(PC_IDX)) |=> (mem[PC_IDX][1:0] == 2'b00));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> (mem[$past(rd_phys[0])] == $past(rd_data[0])));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankrf_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int NUM_RD = 2;
   localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(3);

   if (DATA_W < 8) begin : g_bad_width
      $error("banked_regfile: DATA_W must be at least 8");
   end

   bank_e             bank;
   logic [IDX_W-1:0]  rd_idx   [NUM_RD];
   logic [PHYS_W-1:0] rd_phys  [NUM_RD];
   logic [DATA_W-1:0] rd_data  [NUM_RD];
   logic [PHYS_W-1:0] wr_phys;
   logic [DATA_W-1:0] wr_data_m;

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   bankrf_mode_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_i),
      .bank_o (bank)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
      bankrf_index_map u_map (
         .clk    (clk),
         .rst_n  (rst_n),
         .bank_i (bank),
         .idx_i  (rd_idx[p]),
         .phys_o (rd_phys[p])
      );
   end

   bankrf_index_map u_wmap (
      .clk    (clk),
      .rst_n  (rst_n),
      .bank_i (bank),
      .idx_i  (wr_idx),
      .phys_o (wr_phys)
   );

   assign wr_data_m = (wr_idx == 4'(PC_IDX)) ? (wr_data & ALIGN_MASK) : wr_data;

   bankrf_store #(
      .DATA_W         (DATA_W),
      .NUM_RD         (NUM_RD),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_phys (wr_phys),
      .wr_data (wr_data_m),
      .rd_phys (rd_phys),
      .rd_data (rd_data)
   );

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   assert_same_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

   assert_pc_read_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 4'(PC_IDX)) |-> (rd_a_data[1:0] == 2'b00));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = 5'b10000;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] model [string];

   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                          ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;
   logic [4:0] codes [10] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b00000, 5'b10100, 5'b11110};

   always #2 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   function automatic string key(logic [4:0] m, logic [3:0] i);
      string b;
      case (m)
         FIQ: b = "fiq";
         IRQ: b = "irq";
         SVC: b = "svc";
         ABT: b = "abt";
         UND: b = "und";
         default: b = "usr";
      endcase
      if (i < 8 || i == 15) return $sformatf("c%0d", i);
      if (b == "fiq") return $sformatf("fiq%0d", i);
      if (i >= 13 && b != "usr") return $sformatf("%s%0d", b, i);
      return $sformatf("usr%0d", i);
   endfunction

   function automatic logic [31:0] mget(string k);
      return model.exists(k) ? model[k] : 32'h0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle: drive, compare both ports before the edge, then commit model
   task automatic step(string tag, logic [4:0] m, logic [3:0] ra, logic [3:0] rb,
                       logic we, logic [3:0] wi, logic [31:0] wd);
      @(negedge clk);
      mode_i = m; rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
      #1;
      chk(tag, rd_a_data, mget(key(m, ra)));
      chk(tag, rd_b_data, mget(key(m, rb)));
      @(posedge clk);
      if (we) model[key(m, wi)] = (wi == 4'd15) ? (wd & 32'hFFFF_FFFC) : wd;
   endtask

   task automatic read1(string tag, logic [4:0] m, logic [3:0] ra, logic [31:0] exp);
      @(negedge clk);
      mode_i = m; rd_a_idx = ra; rd_b_idx = ra; wr_en = 1'b0;
      #1;
      chk(tag, rd_a_data, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: everything zero after reset
      for (int c = 0; c < 7; c++)
         for (int i = 0; i < 16; i += 2) step("R1", codes[c], 4'(i), 4'(i + 1), 1'b0, 4'd0, 32'h0);

      // fill user view, read in every mode (R2 R3 R5 R6)
      for (int i = 0; i < 16; i++) step("R2", USR, 4'(i), 4'd0, 1'b1, 4'(i), 32'h1000_0000 + 32'(i * 17 + 1));
      for (int c = 0; c < 10; c++)
         for (int i = 0; i < 16; i++) step("R3", codes[c], 4'(i), 4'(15 - i), 1'b0, 4'd0, 32'h0);
      read1("R6", FIQ, 4'd15, 32'h1000_0000 + 32'(15 * 17 + 1) & 32'hFFFF_FFFC);

      // fast interrupt private r8..r14
      for (int i = 8; i < 15; i++) step("R3", FIQ, 4'(i), 4'(i), 1'b1, 4'(i), 32'hF100_0000 + 32'(i));
      read1("R3", USR, 4'd9, 32'h1000_0000 + 32'(9 * 17 + 1));
      read1("R3", FIQ, 4'd9, 32'hF100_0009);
      read1("R3", IRQ, 4'd12, 32'h1000_0000 + 32'(12 * 17 + 1));

      // R4: each exception bank has its own r13/r14
      for (int c = 2; c < 6; c++) begin
         step("R4", codes[c], 4'd13, 4'd14, 1'b1, 4'd13, 32'h5500_0000 + 32'(c));
         step("R4", codes[c], 4'd13, 4'd14, 1'b1, 4'd14, 32'h6600_0000 + 32'(c));
      end
      for (int c = 0; c < 10; c++) step("R4", codes[c], 4'd13, 4'd14, 1'b0, 4'd0, 32'h0);
      read1("R4", SVC, 4'd13, 32'h5500_0003);
      read1("R4", UND, 4'd14, 32'h6600_0005);
      read1("R4", FIQ, 4'd13, 32'hF100_000D);

      // R5: system writes, user sees
      step("R5", SYS, 4'd13, 4'd10, 1'b1, 4'd13, 32'hABCD_0013);
      read1("R5", USR, 4'd13, 32'hABCD_0013);

      // R6: pc alignment from an exception mode
      step("R6", ABT, 4'd15, 4'd15, 1'b1, 4'd15, 32'hDEAD_BEEF);
      read1("R6", USR, 4'd15, 32'hDEAD_BEEC);

      // R7: same-cycle read returns old value, new value next cycle
      step("R7", IRQ, 4'd13, 4'd13, 1'b1, 4'd13, 32'h7777_0001);
      read1("R7", IRQ, 4'd13, 32'h7777_0001);

      // R8: unlisted codes use user mapping
      read1("R8", 5'b00000, 4'd13, 32'hABCD_0013);
      read1("R8", 5'b10100, 4'd8, 32'h1000_0000 + 32'(8 * 17 + 1));

      // R9: disabled writes do nothing
      step("R9", UND, 4'd13, 4'd3, 1'b0, 4'd13, 32'hBAD0_BAD0);
      step("R9", USR, 4'd3, 4'd7, 1'b0, 4'd3, 32'hBAD0_BAD1);
      read1("R9", UND, 4'd13, 32'h5500_0005);
      read1("R9", USR, 4'd3, 32'h1000_0000 + 32'(3 * 17 + 1));

      // R10: random mix, both ports free
      for (int n = 0; n < 2000; n++)
         step("R10", codes[$urandom_range(0, 9)], 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
              1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule